// File: doc/BRIEF.md
# Packet Header Command Interpreter

This block sits on the receive side of one link channel. It is placed between the character receiver and the receive FIFO. The channel can run in protocol mode. In that mode the first four data characters of each packet form a header, and the block parses them. Byte 0 is the destination address and byte 1 is the command code. Bytes 2 and 3 are parameters.

After the fourth header character the block takes one of three actions:
- It opens the data path, so the rest of the packet goes into the receive FIFO.
- It sends a simple control command and its 16-bit parameter to an external executor.
- It raises an error and discards the packet.

Every header character is also offered to an acknowledge generator. Commands marked safety-critical run only while an external enable is high. In the other modes the block passes every character straight through.

Characters arrive as valid/control/data triples. A control character with data 0x00 is an end-of-packet (EOP) marker. A control character with data 0x01 is an error-end-of-packet (EEP) marker. Every output is registered, so each output event appears one clock cycle after the character that caused it.

Top module: `hdr_cmd_interp`

## Requirements
- R1: In protocol mode (mode 00), each header character is offered on the acknowledge port one cycle after it is accepted. The header is the four data characters that follow reset or any end marker. They are numbered 0, 1, 2, 3 in order, and none of them reaches the FIFO.
- R2: Header byte 0 is compared with the channel address. On a mismatch, the error pulse fires with code 1 in the cycle that carries acknowledge index 3. The address check takes priority over every command check. The rest of the packet up to its end marker produces no output.
- R3: Header byte 1 is looked up in the command table. The default table holds:
  - 0x01 and 0x02: data commands.
  - 0x10 and 0x11: simple commands.
  - 0x20 and 0x21: safety-critical simple commands.
  A code that is not in the table raises error code 2, and the packet is discarded.
- R4: After a data command with a matching address, each later data character appears on the FIFO port one cycle later with the control flag at 0. The closing EOP appears as a control character with data 0x00.
- R5: A permitted simple command pulses the execute request for one cycle, together with acknowledge index 3. The request carries exec_cmd = byte 1 and exec_param = {byte 2, byte 3}. The rest of the packet produces no output.
- R6: A safety-critical command that arrives while safety_en_i is low raises error code 3 and issues no execute request. The same command executes when safety_en_i is high.
- R7: An EOP or EEP that arrives after zero to three header characters raises error code 4. The next data character starts a fresh header at index 0.
- R8: An EEP that arrives during forwarding aborts the packet. The EEP is written to the FIFO as a control character with data 0x01, and the following characters are parsed as a new header.
- R9: In transparent mode (01) and in routing modes (10, 11), every character appears on the FIFO port unchanged one cycle later, markers included. These modes produce no acknowledge, execute or error output. After a marker seen in these modes, a return to protocol mode starts with a header.
- R10: During reset, all output valids are low. The first packet after reset is parsed as a header without a preceding marker. A cycle with no valid input produces no output event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 protocol, 01 transparent, 10/11 routing |
| own_addr_i | input | 8 | Address of this channel |
| safety_en_i | input | 1 | Permits safety-critical commands |
| rx_valid_i | input | 1 | A received character is present |
| rx_ctrl_i | input | 1 | Character is a control marker |
| rx_data_i | input | 8 | Data byte or marker code (0x00 EOP, 0x01 EEP) |
| fifo_valid_o | output | 1 | Write strobe to the receive FIFO |
| fifo_ctrl_o | output | 1 | FIFO entry is a marker |
| fifo_data_o | output | 8 | FIFO entry data |
| ack_valid_o | output | 1 | Header character offered to the acknowledge generator |
| ack_idx_o | output | 2 | Position of that character in the header |
| ack_data_o | output | 8 | Header character |
| exec_valid_o | output | 1 | Execute request pulse |
| exec_cmd_o | output | 8 | Command code of the request |
| exec_param_o | output | 16 | Parameter bytes 2 and 3 |
| err_o | output | 1 | Error pulse |
| err_code_o | output | 3 | 1 address, 2 unknown command, 3 safety blocked, 4 short header |

## Verification
The bench drives these header patterns, each one telling a different decision apart:
- A matching address with a data command.
- A foreign address.
- An unknown code.
- A foreign address combined with an unknown code, which shows the check priority.
- A plain simple command.
- A safety-critical code with the enable low, and again with it high.

A header cut short by an EOP is followed by a full header. This shows that the header index restarts at 0. An EEP inside a forwarded packet shows that the block aborts and then parses a fresh header. Runs in transparent and routing mode with header-like bytes show that the bypass does no interpretation. A reset taken in the middle of a forward shows that parsing starts at once without a marker.

// File: rtl/hci_pkg.sv
package hci_pkg;
    localparam int CHAR_W  = 8;
    localparam int HDR_LEN = 4;
    localparam int IDX_W   = $clog2(HDR_LEN);
    localparam int PRM_W   = 2 * CHAR_W;

    localparam logic [1:0] MODE_PROTO = 2'b00;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_FWD  = 2'd1,
        ST_DROP = 2'd2
    } st_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_ADDR  = 3'd1,
        ERR_CMD   = 3'd2,
        ERR_SAFE  = 3'd3,
        ERR_SHORT = 3'd4
    } err_e;

    typedef struct packed {
        st_e               st;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] h0;
        logic [CHAR_W-1:0] h1;
        logic [CHAR_W-1:0] h2;
        logic              fifo_v;
        logic              fifo_c;
        logic [CHAR_W-1:0] fifo_d;
        logic              ack_v;
        logic [IDX_W-1:0]  ack_i;
        logic [CHAR_W-1:0] ack_d;
        logic              exec_v;
        logic [CHAR_W-1:0] exec_c;
        logic [PRM_W-1:0]  exec_p;
        logic              err_v;
        err_e              err_c;
    } hci_regs_t;
endpackage

// File: rtl/hci_cmd_decode.sv
module hci_cmd_decode
    import hci_pkg::*;
#(
    parameter int                         NUM_CMDS   = 6,
    parameter logic [NUM_CMDS*CHAR_W-1:0] CMD_CODES  = {8'h21, 8'h20, 8'h11, 8'h10, 8'h02, 8'h01},
    parameter logic [NUM_CMDS-1:0]        CMD_SIMPLE = 6'b111100,
    parameter logic [NUM_CMDS-1:0]        CMD_SAFE   = 6'b110000
) (
    input  logic [CHAR_W-1:0] code_i,
    output logic              hit_o,
    output logic              simple_o,
    output logic              safe_o
);
    logic [NUM_CMDS-1:0] match;

    // One comparator per table entry, all evaluated in parallel.
    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_entry
        assign match[i] = (code_i == CMD_CODES[i*CHAR_W +: CHAR_W]);
    end

    assign hit_o    = |match;
    assign simple_o = |(match & CMD_SIMPLE);
    assign safe_o   = |(match & CMD_SAFE);
endmodule

// File: rtl/hci_hdr_ctrl.sv
module hci_hdr_ctrl
    import hci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [CHAR_W-1:0] own_addr_i,
    input  logic              safety_en_i,
    input  logic              rx_valid_i,
    input  logic              rx_ctrl_i,
    input  logic [CHAR_W-1:0] rx_data_i,
    input  logic              cmd_hit_i,
    input  logic              cmd_simple_i,
    input  logic              cmd_safe_i,
    output logic [CHAR_W-1:0] hdr_cmd_o,
    output hci_regs_t         regs_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LEN - 1);

    hci_regs_t q, d;
    logic is_data, is_mark;

    assign is_data = rx_valid_i && !rx_ctrl_i;
    assign is_mark = rx_valid_i && rx_ctrl_i;

    always_comb begin
        d        = q;
        d.fifo_v = 1'b0;
        d.ack_v  = 1'b0;
        d.exec_v = 1'b0;
        d.err_v  = 1'b0;
        d.err_c  = ERR_NONE;

        if (mode_i != MODE_PROTO) begin
            // Bypass: pass every character through, but keep track of packet boundaries.
            if (rx_valid_i) begin
                d.fifo_v = 1'b1;
                d.fifo_c = rx_ctrl_i;
                d.fifo_d = rx_data_i;
            end
            d.idx = '0;
            if (is_mark) begin
                d.st = ST_HDR;
            end else if (is_data) begin
                d.st = ST_DROP;
            end
        end else begin
            case (q.st)
                ST_HDR: begin
                    if (is_data) begin
                        d.ack_v = 1'b1;
                        d.ack_i = q.idx;
                        d.ack_d = rx_data_i;
                        if (q.idx == IDX_W'(0)) d.h0 = rx_data_i;
                        if (q.idx == IDX_W'(1)) d.h1 = rx_data_i;
                        if (q.idx == IDX_W'(2)) d.h2 = rx_data_i;
                        if (q.idx == LAST_IDX) begin
                            // Decide on the fourth header character; checks are in priority order.
                            d.idx = '0;
                            if (q.h0 != own_addr_i) begin
                                d.err_v = 1'b1;
                                d.err_c = ERR_ADDR;
                                d.st    = ST_DROP;
                            end else if (!cmd_hit_i) begin
                                d.err_v = 1'b1;
                                d.err_c = ERR_CMD;
                                d.st    = ST_DROP;
                            end else if (cmd_simple_i) begin
                                if (cmd_safe_i && !safety_en_i) begin
                                    d.err_v = 1'b1;
                                    d.err_c = ERR_SAFE;
                                end else begin
                                    d.exec_v = 1'b1;
                                    d.exec_c = q.h1;
                                    d.exec_p = {q.h2, rx_data_i};
                                end
                                d.st = ST_DROP;
                            end else begin
                                d.st = ST_FWD;
                            end
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end else if (is_mark) begin
                        d.err_v = 1'b1;
                        d.err_c = ERR_SHORT;
                        d.idx   = '0;
                    end
                end
                ST_FWD: begin
                    if (rx_valid_i) begin
                        d.fifo_v = 1'b1;
                        d.fifo_c = rx_ctrl_i;
                        d.fifo_d = rx_data_i;
                    end
                    if (is_mark) begin
                        d.st  = ST_HDR;
                        d.idx = '0;
                    end
                end
                ST_DROP: begin
                    if (is_mark) begin
                        d.st  = ST_HDR;
                        d.idx = '0;
                    end
                end
                default: begin
                    d.st  = ST_HDR;
                    d.idx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hdr_cmd_o = q.h1;
    assign regs_o    = q;
endmodule

// File: rtl/hdr_cmd_interp.sv
module hdr_cmd_interp
    import hci_pkg::*;
#(
    parameter int                         NUM_CMDS   = 6,
    parameter logic [NUM_CMDS*CHAR_W-1:0] CMD_CODES  = {8'h21, 8'h20, 8'h11, 8'h10, 8'h02, 8'h01},
    parameter logic [NUM_CMDS-1:0]        CMD_SIMPLE = 6'b111100,
    parameter logic [NUM_CMDS-1:0]        CMD_SAFE   = 6'b110000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [CHAR_W-1:0] own_addr_i,
    input  logic              safety_en_i,
    input  logic              rx_valid_i,
    input  logic              rx_ctrl_i,
    input  logic [CHAR_W-1:0] rx_data_i,
    output logic              fifo_valid_o,
    output logic              fifo_ctrl_o,
    output logic [CHAR_W-1:0] fifo_data_o,
    output logic              ack_valid_o,
    output logic [IDX_W-1:0]  ack_idx_o,
    output logic [CHAR_W-1:0] ack_data_o,
    output logic              exec_valid_o,
    output logic [CHAR_W-1:0] exec_cmd_o,
    output logic [PRM_W-1:0]  exec_param_o,
    output logic              err_o,
    output logic [2:0]        err_code_o
);
    logic [CHAR_W-1:0] hdr_cmd;
    logic              cmd_hit, cmd_simple, cmd_safe;
    hci_regs_t         regs;

    hci_cmd_decode #(
        .NUM_CMDS   (NUM_CMDS),
        .CMD_CODES  (CMD_CODES),
        .CMD_SIMPLE (CMD_SIMPLE),
        .CMD_SAFE   (CMD_SAFE)
    ) u_dec (
        .code_i   (hdr_cmd),
        .hit_o    (cmd_hit),
        .simple_o (cmd_simple),
        .safe_o   (cmd_safe)
    );

    hci_hdr_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .own_addr_i   (own_addr_i),
        .safety_en_i  (safety_en_i),
        .rx_valid_i   (rx_valid_i),
        .rx_ctrl_i    (rx_ctrl_i),
        .rx_data_i    (rx_data_i),
        .cmd_hit_i    (cmd_hit),
        .cmd_simple_i (cmd_simple),
        .cmd_safe_i   (cmd_safe),
        .hdr_cmd_o    (hdr_cmd),
        .regs_o       (regs)
    );

    assign fifo_valid_o = regs.fifo_v;
    assign fifo_ctrl_o  = regs.fifo_c;
    assign fifo_data_o  = regs.fifo_d;
    assign ack_valid_o  = regs.ack_v;
    assign ack_idx_o    = regs.ack_i;
    assign ack_data_o   = regs.ack_d;
    assign exec_valid_o = regs.exec_v;
    assign exec_cmd_o   = regs.exec_c;
    assign exec_param_o = regs.exec_p;
    assign err_o        = regs.err_v;
    assign err_code_o   = regs.err_c;
endmodule

// File: rtl/hci_checker.sv
module hci_checker
    import hci_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              safety_en_i,
    input logic              rx_valid_i,
    input logic              rx_ctrl_i,
    input logic [CHAR_W-1:0] rx_data_i,
    input logic              fifo_valid_o,
    input logic              fifo_ctrl_o,
    input logic [CHAR_W-1:0] fifo_data_o,
    input logic              ack_valid_o,
    input logic [IDX_W-1:0]  ack_idx_o,
    input logic              exec_valid_o,
    input logic              err_o,
    input logic [2:0]        err_code_o
);
    assert_hdr_not_fifo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> !fifo_valid_o);

    assert_hdr_err_at_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && (err_code_o == ERR_ADDR || err_code_o == ERR_CMD || err_code_o == ERR_SAFE))
        |-> (ack_valid_o && ack_idx_o == IDX_W'(HDR_LEN - 1)));

    assert_exec_at_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid_o |-> (ack_valid_o && ack_idx_o == IDX_W'(HDR_LEN - 1) && !err_o && !fifo_valid_o));

    assert_safe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == ERR_SAFE) |-> !$past(safety_en_i));

    assert_short_on_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == ERR_SHORT) |-> $past(rx_valid_i && rx_ctrl_i));

    assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && mode_i != MODE_PROTO) |=>
        (fifo_valid_o && fifo_ctrl_o == $past(rx_ctrl_i) && fifo_data_o == $past(rx_data_i)));

    assert_bypass_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_PROTO) |=> !(ack_valid_o || exec_valid_o || err_o));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_i |=> !(fifo_valid_o || ack_valid_o || exec_valid_o || err_o));
endmodule

bind hdr_cmd_interp hci_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .safety_en_i  (safety_en_i),
    .rx_valid_i   (rx_valid_i),
    .rx_ctrl_i    (rx_ctrl_i),
    .rx_data_i    (rx_data_i),
    .fifo_valid_o (fifo_valid_o),
    .fifo_ctrl_o  (fifo_ctrl_o),
    .fifo_data_o  (fifo_data_o),
    .ack_valid_o  (ack_valid_o),
    .ack_idx_o    (ack_idx_o),
    .exec_valid_o (exec_valid_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/hdr_cmd_interp_test.sv
module hdr_cmd_interp_test;
    localparam logic [1:0] P = 2'b00;
    localparam logic [1:0] T = 2'b01;
    localparam logic [1:0] W = 2'b10;
    localparam logic [7:0] OWN = 8'h5A;

    typedef struct packed {
        logic [1:0]  mode;
        logic        saf;
        logic        v;
        logic        c;
        logic [7:0]  d;
        logic        fv;
        logic        fc;
        logic [7:0]  fd;
        logic        av;
        logic [1:0]  ai;
        logic        xv;
        logic [7:0]  xc;
        logic [15:0] xp;
        logic        ev;
        logic [2:0]  ec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 65;
    localparam vec_t VECS [NV] = '{
        // R10, R1: first packet after reset, data command 0x01
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd10},
        '{P,1'b0,1'b1,1'b0,8'h01, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd1},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd1},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd1},
        // R4: forwarding
        '{P,1'b0,1'b1,1'b0,8'h11, 1'b1,1'b0,8'h11, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd4},
        '{P,1'b0,1'b1,1'b0,8'h22, 1'b1,1'b0,8'h22, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd4},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b1,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd4},
        // R10: idle cycle
        '{P,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd10},
        // R7: marker with zero header characters
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b1,3'd4, 4'd7},
        // R2: address mismatch
        '{P,1'b0,1'b1,1'b0,8'h33, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h01, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b1,3'd1, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h44, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        // R3: unknown command code 0x7F
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd3},
        '{P,1'b0,1'b1,1'b0,8'h7F, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd3},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd3},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b1,3'd2, 4'd3},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd3},
        // R2: foreign address and unknown code, address wins
        '{P,1'b0,1'b1,1'b0,8'h33, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h7F, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b1,3'd1, 4'd2},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd2},
        // R5: simple command 0x10
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd5},
        '{P,1'b0,1'b1,1'b0,8'h10, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd5},
        '{P,1'b0,1'b1,1'b0,8'hAB, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd5},
        '{P,1'b0,1'b1,1'b0,8'hCD, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b1,8'h10,16'hABCD, 1'b0,3'd0, 4'd5},
        '{P,1'b0,1'b1,1'b0,8'h99, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd5},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd5},
        // R6: safety-critical 0x20 blocked
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        '{P,1'b0,1'b1,1'b0,8'h20, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        '{P,1'b0,1'b1,1'b0,8'h07, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b1,3'd3, 4'd6},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        // R6: safety-critical 0x20 permitted
        '{P,1'b1,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        '{P,1'b1,1'b1,1'b0,8'h20, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        '{P,1'b1,1'b1,1'b0,8'h12, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        '{P,1'b1,1'b1,1'b0,8'h34, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b1,8'h20,16'h1234, 1'b0,3'd0, 4'd6},
        '{P,1'b1,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd6},
        // R7: short header, then restart at index 0
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd7},
        '{P,1'b0,1'b1,1'b0,8'h01, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd7},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b1,3'd4, 4'd7},
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd7},
        '{P,1'b0,1'b1,1'b0,8'h02, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd7},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd7},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd7},
        // R8: EEP during forwarding, then a new header
        '{P,1'b0,1'b1,1'b0,8'h77, 1'b1,1'b0,8'h77, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b1,8'h01, 1'b1,1'b1,8'h01, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b0,8'h01, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b0,8'h66, 1'b1,1'b0,8'h66, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd8},
        '{P,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b1,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd4},
        // R9: transparent and routing bypass
        '{T,1'b0,1'b1,1'b0,8'h5A, 1'b1,1'b0,8'h5A, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{T,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b1,8'h00, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{W,1'b0,1'b1,1'b0,8'h01, 1'b1,1'b0,8'h01, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{W,1'b0,1'b1,1'b1,8'h01, 1'b1,1'b1,8'h01, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        // R9: back in protocol mode after a marker, a header follows
        '{P,1'b0,1'b1,1'b0,8'h5A, 1'b0,1'b0,8'h00, 1'b1,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{P,1'b0,1'b1,1'b0,8'h01, 1'b0,1'b0,8'h00, 1'b1,2'd1, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd2, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{P,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,8'h00, 1'b1,2'd3, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9},
        '{P,1'b0,1'b1,1'b0,8'h3C, 1'b1,1'b0,8'h3C, 1'b0,2'd0, 1'b0,8'h00,16'h0000, 1'b0,3'd0, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        safety_en_i;
    logic        rx_valid_i;
    logic        rx_ctrl_i;
    logic [7:0]  rx_data_i;
    logic        fifo_valid_o, fifo_ctrl_o;
    logic [7:0]  fifo_data_o;
    logic        ack_valid_o;
    logic [1:0]  ack_idx_o;
    logic [7:0]  ack_data_o;
    logic        exec_valid_o;
    logic [7:0]  exec_cmd_o;
    logic [15:0] exec_param_o;
    logic        err_o;
    logic [2:0]  err_code_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hdr_cmd_interp uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .own_addr_i   (OWN),
        .safety_en_i  (safety_en_i),
        .rx_valid_i   (rx_valid_i),
        .rx_ctrl_i    (rx_ctrl_i),
        .rx_data_i    (rx_data_i),
        .fifo_valid_o (fifo_valid_o),
        .fifo_ctrl_o  (fifo_ctrl_o),
        .fifo_data_o  (fifo_data_o),
        .ack_valid_o  (ack_valid_o),
        .ack_idx_o    (ack_idx_o),
        .ack_data_o   (ack_data_o),
        .exec_valid_o (exec_valid_o),
        .exec_cmd_o   (exec_cmd_o),
        .exec_param_o (exec_param_o),
        .err_o        (err_o),
        .err_code_o   (err_code_o)
    );

    // Inputs change at a falling edge; outputs are read at the next falling edge.
    task automatic send(input logic [1:0] m, input logic s, input logic v, input logic c, input logic [7:0] d);
        mode_i      = m;
        safety_en_i = s;
        rx_valid_i  = v;
        rx_ctrl_i   = c;
        rx_data_i   = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_quiet(input string tag);
        checks++;
        if (fifo_valid_o || ack_valid_o || exec_valid_o || err_o) begin
            errors++;
            $display("FAIL %s: got fv=%b av=%b xv=%b ev=%b, expected all 0",
                     tag, fifo_valid_o, ack_valid_o, exec_valid_o, err_o);
        end
    endtask

    task automatic check_ack(input string tag, input logic [1:0] idx, input logic [7:0] dat);
        checks++;
        if (!ack_valid_o || ack_idx_o != idx || ack_data_o != dat || fifo_valid_o || err_o) begin
            errors++;
            $display("FAIL %s: got av=%b ai=%0d ad=%h fv=%b ev=%b, expected av=1 ai=%0d ad=%h fv=0 ev=0",
                     tag, ack_valid_o, ack_idx_o, ack_data_o, fifo_valid_o, err_o, idx, dat);
        end
    endtask

    initial begin
        rst_n       = 1'b0;
        mode_i      = P;
        safety_en_i = 1'b0;
        rx_valid_i  = 1'b0;
        rx_ctrl_i   = 1'b0;
        rx_data_i   = 8'h00;
        repeat (3) @(negedge clk);
        check_quiet("R10 reset state");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t e;
            bit   bad;
            e = VECS[i];
            send(e.mode, e.saf, e.v, e.c, e.d);
            bad = (fifo_valid_o != e.fv) || (ack_valid_o != e.av) ||
                  (exec_valid_o != e.xv) || (err_o != e.ev);
            if (e.fv && (fifo_ctrl_o != e.fc || fifo_data_o != e.fd)) bad = 1'b1;
            if (e.av && (ack_idx_o != e.ai || ack_data_o != e.d)) bad = 1'b1;
            if (e.xv && (exec_cmd_o != e.xc || exec_param_o != e.xp)) bad = 1'b1;
            if (e.ev && err_code_o != e.ec) bad = 1'b1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL vector %0d R%0d: got fv=%b fc=%b fd=%h av=%b ai=%0d ad=%h xv=%b xc=%h xp=%h ev=%b ec=%0d; expected fv=%b fc=%b fd=%h av=%b ai=%0d ad=%h xv=%b xc=%h xp=%h ev=%b ec=%0d",
                         i, e.req, fifo_valid_o, fifo_ctrl_o, fifo_data_o, ack_valid_o, ack_idx_o, ack_data_o,
                         exec_valid_o, exec_cmd_o, exec_param_o, err_o, err_code_o,
                         e.fv, e.fc, e.fd, e.av, e.ai, e.d, e.xv, e.xc, e.xp, e.ev, e.ec);
            end
        end

        // R10: reset in the middle of a forwarded packet, then parse at once with no marker.
        send(P, 1'b0, 1'b1, 1'b0, 8'h21);
        send(P, 1'b0, 1'b1, 1'b0, 8'h55);
        checks++;
        if (!fifo_valid_o || fifo_data_o != 8'h55) begin
            errors++;
            $display("FAIL R10 pre-reset forward: got fv=%b fd=%h, expected fv=1 fd=55", fifo_valid_o, fifo_data_o);
        end
        rst_n = 1'b0;
        send(P, 1'b0, 1'b1, 1'b0, 8'h66);
        check_quiet("R10 reset during forwarding");
        rst_n = 1'b1;
        send(P, 1'b0, 1'b1, 1'b0, 8'h5A);
        check_ack("R10 header after reset", 2'd0, 8'h5A);
        send(P, 1'b0, 1'b1, 1'b0, 8'h11);
        check_ack("R1 second header char", 2'd1, 8'h11);
        send(P, 1'b0, 1'b1, 1'b0, 8'hE1);
        check_ack("R1 third header char", 2'd2, 8'hE1);
        send(P, 1'b0, 1'b1, 1'b0, 8'hE2);
        checks++;
        if (!exec_valid_o || exec_cmd_o != 8'h11 || exec_param_o != 16'hE1E2 || err_o) begin
            errors++;
            $display("FAIL R5 simple 0x11: got xv=%b xc=%h xp=%h ev=%b, expected xv=1 xc=11 xp=e1e2 ev=0",
                     exec_valid_o, exec_cmd_o, exec_param_o, err_o);
        end
        // R3: 0x21 is in the table as safety-critical and is blocked here with code 3
        send(P, 1'b0, 1'b1, 1'b1, 8'h00);
        send(P, 1'b0, 1'b1, 1'b0, 8'h5A);
        send(P, 1'b0, 1'b1, 1'b0, 8'h21);
        send(P, 1'b0, 1'b1, 1'b0, 8'h00);
        send(P, 1'b0, 1'b1, 1'b0, 8'h00);
        checks++;
        if (!err_o || err_code_o != 3'd3 || exec_valid_o) begin
            errors++;
            $display("FAIL R6 blocked 0x21: got ev=%b ec=%0d xv=%b, expected ev=1 ec=3 xv=0", err_o, err_code_o, exec_valid_o);
        end
        send(P, 1'b0, 1'b0, 1'b0, 8'h00);
        check_quiet("R10 idle after error");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule